// File: doc/BRIEF.md
# Power Partition Gate Controller

The controller switches up to 32 power partitions on and off. It also manages the isolation clamps that keep a partition's outputs at safe levels while its supply is not valid. Software reaches it through a simple 32-bit register bus. Each partition has a request line to its external power switch, an acknowledge line from that switch, and a clamp output.

A power change is started by writing a partition index together with a start flag. The selected partition changes to the opposite of its current state; software does not write the state it wants. The start flag reads back as 1 until the switch has acknowledged. When a partition is turned off, the controller clamps it again one cycle before it drops the switch request.

Clamps are released through a separate one-hot command register. Each command bit clears itself once the release is done. Two designated command bit positions are crossed over, so each acts on the other's partition. The clamp status is always reported at the true partition index.

Top module: `pwr_part_gate`

## Requirements
- R1: After reset, every partition reads unpowered (power status, word 1, all zero) and clamped (clamp status, word 3, all ones). Every switch request is low, every command bit is clear, the error word (word 4) is zero, and the toggle word (word 0) reads zero.
- R2: The toggle word is word 0, with the partition index in bits 4:0 and the start flag in bit 8. A write with bit 8 set, issued while idle, starts a toggle of that partition. A write with bit 8 clear has no effect.
- R3: Toggling an unpowered partition raises its switch request in the cycle after the write. Its power status bit becomes 1 once the acknowledge has been seen high. Its clamp stays asserted throughout.
- R4: Toggling a powered partition asserts its clamp in the cycle after the write. The switch request drops one cycle later. The power status bit clears once the acknowledge has been seen low.
- R5: While a toggle is in progress, the toggle word reads bit 8 as 1 and bits 4:0 as the index being toggled. Bit 8 returns to 0 when the toggle completes.
- R6: A toggle-word write that arrives while a toggle is in progress is ignored: no other switch request moves and the readback index is kept. It sets error bit 0.
- R7: Writing a 1 to bit n of the command word (word 2) for a powered partition makes that bit read 1 for one cycle. The bit then clears, and the clamp output and the clamp status bit of that partition drop in the same cycle.
- R8: Command bits 8 and 12 are crossed over. Bit 8 releases partition 12 and bit 12 releases partition 8. The powered check and the clamp status both use the true partition index. All other bits map straight through.
- R9: A command bit whose target partition is unpowered, or is being turned off, is never set. The clamp stays asserted and error bit 1 is set.
- R10: The error word is write-one-to-clear: writing a 1 clears that bit and leaves the other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word select (0 toggle, 1 power status, 2 clamp command, 3 clamp status, 4 error) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word, combinational |
| sw_req | output | 32 | Per-partition power switch request |
| sw_ack | input | 32 | Per-partition power switch acknowledge |
| clamp_on | output | 32 | Per-partition isolation clamp, 1 = clamped |

## Verification
The bench concentrates on the ordering when a partition is turned off. If the request dropped before the clamp came back, sw_req would already be low in the cycle in which clamp_on rises. It also covers a second toggle written during a slow acknowledge. A design without the busy guard would start a second switch request and lose the first index.

The crossed-over command bits are tested in both directions. One direction has the target powered and the other has it unpowered, so a design that skipped the remap would release the wrong clamp or flag the wrong error. Finally, commands aimed at unpowered partitions are sent. A design that accepted them would drop a clamp while the supply is not valid.

// File: rtl/pwr_part_gate.sv
module pwr_part_gate #(
  parameter int NPART  = 32,
  parameter int SWAP_A = 8,
  parameter int SWAP_B = 12,
  parameter int AW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPART-1:0] sw_req,
  input  logic [NPART-1:0] sw_ack,
  output logic [NPART-1:0] clamp_on
);
  localparam logic [AW-1:0] A_TOG = AW'(0);
  localparam logic [AW-1:0] A_PWR = AW'(1);
  localparam logic [AW-1:0] A_CMD = AW'(2);
  localparam logic [AW-1:0] A_CLS = AW'(3);
  localparam logic [AW-1:0] A_ERR = AW'(4);

  function automatic int remap(int j);
    if (j == SWAP_A) return SWAP_B;
    if (j == SWAP_B) return SWAP_A;
    return j;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_UP, S_CLAMP, S_DOWN} st_t;

  st_t              st;
  logic [4:0]       idx_q;
  logic [NPART-1:0] pwr_q, req_q, clamp_q, cmd_q;
  logic [1:0]       err_q;

  logic             busy, tog_wr, cmd_wr, err_wr, launch, tog_err;
  logic [4:0]       w_idx;
  logic [NPART-1:0] sel, wsel, pwr_eff, pwr_at_cmd, cmd_to_part;
  logic [NPART-1:0] cmd_mask, cmd_ok, cmd_bad, clamp_nxt;

  assign busy    = (st != S_IDLE);
  assign tog_wr  = bus_wr && (bus_addr == A_TOG);
  assign cmd_wr  = bus_wr && (bus_addr == A_CMD);
  assign err_wr  = bus_wr && (bus_addr == A_ERR);
  assign w_idx   = bus_wdata[4:0];
  assign launch  = tog_wr && bus_wdata[8] && !busy && (int'(w_idx) < NPART);
  assign tog_err = tog_wr && busy;
  assign sel     = NPART'(1) << idx_q;
  assign wsel    = NPART'(1) << w_idx;

  assign pwr_eff = pwr_q & ~(((st == S_CLAMP) || (st == S_DOWN)) ? sel : '0);

  for (genvar j = 0; j < NPART; j++) begin : g_map
    localparam int M = remap(j);
    assign pwr_at_cmd[j]  = pwr_eff[M];
    assign cmd_to_part[M] = cmd_q[j];
  end

  assign cmd_mask  = cmd_wr ? bus_wdata[NPART-1:0] : '0;
  assign cmd_ok    = cmd_mask & pwr_at_cmd;
  assign cmd_bad   = cmd_mask & ~pwr_at_cmd;
  assign clamp_nxt = (clamp_q & ~cmd_to_part) |
                     ((launch && |(pwr_q & wsel)) ? wsel : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx_q   <= '0;
      pwr_q   <= '0;
      req_q   <= '0;
      clamp_q <= '1;
      cmd_q   <= '0;
      err_q   <= '0;
    end else begin
      clamp_q <= clamp_nxt;
      cmd_q   <= cmd_ok;
      err_q   <= (err_wr ? (err_q & ~bus_wdata[1:0]) : err_q) | {|cmd_bad, tog_err};
      case (st)
        S_IDLE: if (launch) begin
          idx_q <= w_idx;
          if (|(pwr_q & wsel)) st <= S_CLAMP;
          else begin
            req_q <= req_q | wsel;
            st    <= S_UP;
          end
        end
        S_UP: if (|(sw_ack & sel)) begin
          pwr_q <= pwr_q | sel;
          st    <= S_IDLE;
        end
        S_CLAMP: begin
          req_q <= req_q & ~sel;
          st    <= S_DOWN;
        end
        S_DOWN: if (!(|(sw_ack & sel))) begin
          pwr_q <= pwr_q & ~sel;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TOG:   bus_rdata = {23'b0, busy, 3'b0, idx_q};
      A_PWR:   bus_rdata[NPART-1:0] = pwr_q;
      A_CMD:   bus_rdata[NPART-1:0] = cmd_q;
      A_CLS:   bus_rdata[NPART-1:0] = clamp_q;
      A_ERR:   bus_rdata[1:0] = err_q;
      default: bus_rdata = '0;
    endcase
  end

  assign sw_req   = req_q;
  assign clamp_on = clamp_q;
endmodule

// File: rtl/pwr_part_gate_chk.sv
module pwr_part_gate_chk #(
  parameter int NPART = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPART-1:0] sw_req,
  input logic [NPART-1:0] sw_ack,
  input logic [NPART-1:0] clamp_on,
  input logic [NPART-1:0] pwr_q,
  input logic             busy
);
  // R4
  clamp_before_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_req) & ~sw_req & ~$past(clamp_on)) == '0);

  // R9
  release_only_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clamp_on) & ~clamp_on & ~$past(pwr_q)) == '0);

  // R6
  one_req_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_req ^ $past(sw_req)) <= 1);

  // R3
  up_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q & ~$past(pwr_q) & ~$past(sw_ack)) == '0);

  // R5
  idle_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sw_req == pwr_q));
endmodule

bind pwr_part_gate pwr_part_gate_chk #(.NPART(NPART)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_ack(sw_ack),
  .clamp_on(clamp_on), .pwr_q(pwr_q), .busy(busy)
);

// File: tb/test_pwr_part_gate.sv
module test_pwr_part_gate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [31:0] sw_req, sw_ack, clamp_on;
  int checks = 0, errors = 0;
  int ack_dly = 3;
  int cnt [32];

  always #4 clk = ~clk;

  pwr_part_gate i_pwr_part_gate (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_req(sw_req),
    .sw_ack(sw_ack), .clamp_on(clamp_on)
  );

  initial sw_ack = '0;
  always @(posedge clk) begin
    for (int i = 0; i < 32; i++) begin
      if (sw_ack[i] != sw_req[i]) begin
        if (cnt[i] >= ack_dly - 1) begin
          sw_ack[i] <= sw_req[i];
          cnt[i] <= 0;
        end else cnt[i] <= cnt[i] + 1;
      end else cnt[i] <= 0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      peek(3'd0, d);
      if (!d[8]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    peek(3'd1, d); chk(d == 0, "R1 power status", d, 0);
    peek(3'd3, d); chk(d == '1, "R1 clamp status", d, '1);
    peek(3'd4, d); chk(d == 0, "R1 error word", d, 0);
    peek(3'd0, d); chk(d == 0, "R1 toggle word", d, 0);
    peek(3'd2, d); chk(d == 0, "R1 command word", d, 0);
    chk(sw_req == 0, "R1 sw_req", sw_req, 0);
  endtask

  task automatic t_start_zero();
    logic [31:0] d;
    wr(3'd0, 32'h3);
    peek(3'd0, d); chk(d[8] == 0, "R2 start clear no busy", d, 0);
    chk(sw_req == 0, "R2 start clear no req", sw_req, 0);
  endtask

  task automatic t_power_up(input int n);
    logic [31:0] d;
    wr(3'd0, 32'h100 | n);
    chk(sw_req[n] == 1, "R3 req rises", sw_req, 32'(1) << n);
    peek(3'd0, d); chk(d == (32'h100 | n), "R5 busy readback", d, 32'h100 | n);
    wait_idle();
    peek(3'd1, d); chk(d[n] == 1, "R3 powered", d, 32'(1) << n);
    chk(clamp_on[n] == 1, "R3 clamp kept", clamp_on, '1);
    peek(3'd0, d); chk(d[8] == 0, "R5 busy clears", d, n);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    ack_dly = 10;
    wr(3'd0, 32'h106);
    wr(3'd0, 32'h107);
    chk(sw_req[7] == 0, "R6 second req blocked", sw_req, 0);
    peek(3'd0, d); chk(d[4:0] == 6, "R6 index kept", d, 32'h106);
    peek(3'd4, d); chk(d[0] == 1, "R6 error bit0", d, 1);
    wait_idle();
    peek(3'd1, d); chk(d[7:6] == 2'b01, "R6 only 6 powered", d, 32'h40);
    ack_dly = 3;
  endtask

  task automatic t_release(input int n);
    logic [31:0] d;
    wr(3'd2, 32'(1) << n);
    peek(3'd2, d); chk(d == (32'(1) << n), "R7 command bit set", d, 32'(1) << n);
    chk(clamp_on[n] == 1, "R7 clamp before release", clamp_on, '1);
    @(negedge clk);
    peek(3'd2, d); chk(d == 0, "R7 command self clears", d, 0);
    chk(clamp_on[n] == 0, "R7 clamp released", clamp_on, 0);
    peek(3'd3, d); chk(d[n] == 0, "R7 clamp status", d, 0);
  endtask

  task automatic t_unpowered();
    logic [31:0] d;
    wr(3'd2, 32'(1) << 9);
    peek(3'd2, d); chk(d == 0, "R9 command never set", d, 0);
    peek(3'd4, d); chk(d[1] == 1, "R9 error bit1", d, 2);
    @(negedge clk);
    chk(clamp_on[9] == 1, "R9 clamp kept", clamp_on, '1);
  endtask

  task automatic t_err_clear();
    logic [31:0] d;
    wr(3'd4, 32'h1);
    peek(3'd4, d); chk(d == 2, "R10 clear bit0 only", d, 2);
    wr(3'd4, 32'h2);
    peek(3'd4, d); chk(d == 0, "R10 clear bit1", d, 0);
  endtask

  task automatic t_remap();
    logic [31:0] d;
    t_power_up(12);
    wr(3'd2, 32'(1) << 8);
    peek(3'd4, d); chk(d == 0, "R8 bit8 accepted", d, 0);
    @(negedge clk);
    chk(clamp_on[12] == 0, "R8 bit8 releases 12", clamp_on, 0);
    chk(clamp_on[8] == 1, "R8 partition 8 kept", clamp_on, '1);
    wr(3'd2, 32'(1) << 12);
    peek(3'd4, d); chk(d[1] == 1, "R8 bit12 targets unpowered 8", d, 2);
    wr(3'd4, 32'h3);
  endtask

  task automatic t_power_down(input int n);
    logic [31:0] d;
    wr(3'd0, 32'h100 | n);
    chk(clamp_on[n] == 1, "R4 clamp first", clamp_on, '1);
    chk(sw_req[n] == 1, "R4 req still high", sw_req, 32'(1) << n);
    @(negedge clk);
    chk(sw_req[n] == 0, "R4 req dropped", sw_req, 0);
    wait_idle();
    peek(3'd1, d); chk(d[n] == 0, "R4 unpowered", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start_zero();
    t_power_up(5);
    t_busy_write();
    wr(3'd4, 32'h3);
    t_release(5);
    t_unpowered();
    wr(3'd0, 32'h105);
    wr(3'd0, 32'h105);
    wait_idle();
    t_err_clear();
    t_power_up(5);
    t_remap();
    t_release(5);
    t_power_down(5);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule